// File: doc/BRIEF.md
# Run Controller with Time and Event Limits

This block governs a data-taking run. Software sees it through a small file of 16-bit registers. Writing the control register starts or stops the run. Two mode bits can also let the block end the run by itself. One mode stops the run after a number of 1 ms ticks, and the other stops it after a number of accepted events. When a run begins, the block takes a 64-bit copy of the time-of-day input and keeps it. It also reports whether the flag field of that copy marks the time as trustworthy.

The core is a two-state machine. `ST_IDLE` moves to `ST_RUN` on the transition *start* (a write of 1 to control bit 0 while idle). `ST_RUN` returns to `ST_IDLE` on one of three transitions: *stop* (a write of 0 to control bit 0), *time-limit* (an enabled tick that reaches the millisecond limit) or *event-limit* (an enabled strobe that reaches the event limit). *Stop* has top priority. Every other condition is a *hold*, and the machine stays in its present state. Two counters, one for milliseconds and one for events, are cleared in the cycle of *start*. They advance only while the run is active.

Register indices (word addresses) are as follows:
- 0: mode. Bit 0 enables the time limit and bit 1 enables the event limit.
- 1: control/status.
- 2 to 5: captured start time, read-only, lowest 16 bits first.
- 6 and 7: millisecond limit.
- 8 and 9: event limit.

Read data is combinational from `reg_addr`.

Top module: `run_ctrl_top`

## Requirements
- R1: After reset, `run_active` is 0, `start_time` is 0, `start_valid` is 0, and every register index reads 0.
- R2: Mode (index 0, bits [1:0]) and the two 32-bit limits (indices 6–7 and 8–9) read back as written. The low 16 bits sit at the lower index. Indices outside 0–9 read 0.
- R3: A write with bit 0 = 1 to index 1 while idle makes `run_active` 1 from the next cycle. Bit 0 of index 1 reads the run state. With no write, an idle run stays idle.
- R4: With mode 0, ticks and events never end a run; only a software stop does.
- R5: With mode bit 0 set, the run ends on the `ms_tick` (counted from after the start cycle) at which the elapsed count reaches the millisecond limit. A limit of 0 acts as 1. Events do not advance this count.
- R6: With mode bit 1 set, the run ends on the `evt_accept` strobe at which the accepted count reaches the event limit. Ticks do not advance this count. Without a tick, strobe or stop, an active run stays active.
- R7: With both mode bits set, whichever limit is reached first ends the run.
- R8: A write of bit 0 = 0 to index 1 makes `run_active` 0 in the next cycle. This holds in any mode and even when a limit is not reached in that cycle.
- R9: In the start cycle `start_time` takes `tod_in`, with seconds in [63:32], nanoseconds in [31:2] and flags in [1:0]. It is readable at indices 2–5, lowest 16 bits first.
- R10: `start_valid` is 1 exactly when the captured flags equal 2.
- R11: A start write while running is ignored: the run continues and `start_time` is kept. Ticks and events while idle do not count toward the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| evt_accept | input | 1 | One-cycle pulse per accepted event |
| tod_in | input | 64 | Current time of day with flags |
| run_active | output | 1 | Run in progress |
| start_time | output | 64 | Time captured at run start |
| start_valid | output | 1 | Captured flags equal 2 |

## Verification
On every cycle the assertions check four things. A stop write always leaves the run idle. An idle run never leaves idle without a start write. A run in software-only mode, or one with no tick, strobe or stop, survives the cycle. The captured time matches the previous cycle's `tod_in` and then stays put. The exact tick or strobe on which a limit fires needs the bench's scenarios to show it. So do the limit-of-zero case, the race between the two limits, the register read-back layout and the validity flag.

// File: rtl/run_ctrl_pkg.sv
package run_ctrl_pkg;
    localparam int REG_W   = 16;
    localparam int TIME_W  = 64;
    localparam int TIME_WORDS = TIME_W / REG_W;
    localparam int IDX_MODE  = 0;
    localparam int IDX_CTRL  = 1;
    localparam int IDX_STAMP = 2;
    localparam logic [1:0] FLAG_VALID = 2'b10;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/run_regs.sv
module run_regs
    import run_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LIMIT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 running,
    input  logic [TIME_W-1:0]    stamp,
    output logic [1:0]           mode,
    output logic [LIMIT_W-1:0]   ms_limit,
    output logic [LIMIT_W-1:0]   ev_limit,
    output logic [REG_W-1:0]     rdata
);
    localparam int LIM_WORDS = LIMIT_W / REG_W;
    localparam int IDX_MSLIM = IDX_STAMP + TIME_WORDS;
    localparam int IDX_EVLIM = IDX_MSLIM + LIM_WORDS;

    logic [1:0] mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= '0;
        else if (wr_en && addr == ADDR_W'(IDX_MODE))
            mode_q <= wdata[1:0];
    end
    assign mode = mode_q;

    for (genvar w = 0; w < LIM_WORDS; w++) begin : g_lim
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ms_limit[w*REG_W +: REG_W] <= '0;
                ev_limit[w*REG_W +: REG_W] <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(IDX_MSLIM + w))
                    ms_limit[w*REG_W +: REG_W] <= wdata;
                if (addr == ADDR_W'(IDX_EVLIM + w))
                    ev_limit[w*REG_W +: REG_W] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(IDX_MODE))
            rdata = {{(REG_W-2){1'b0}}, mode_q};
        if (addr == ADDR_W'(IDX_CTRL))
            rdata = {{(REG_W-1){1'b0}}, running};
        for (int i = 0; i < TIME_WORDS; i++)
            if (addr == ADDR_W'(IDX_STAMP + i))
                rdata = stamp[i*REG_W +: REG_W];
        for (int i = 0; i < LIM_WORDS; i++) begin
            if (addr == ADDR_W'(IDX_MSLIM + i))
                rdata = ms_limit[i*REG_W +: REG_W];
            if (addr == ADDR_W'(IDX_EVLIM + i))
                rdata = ev_limit[i*REG_W +: REG_W];
        end
    end
endmodule

// File: rtl/run_limit.sv
module run_limit #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             running,
    input  logic             pulse,
    input  logic             enable,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + (CNT_W+1)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (running && pulse)
            cnt_q <= cnt_next[CNT_W-1:0];
    end

    // a limit of zero is met by the first pulse, as is a limit of one
    assign hit = running && enable && pulse && (cnt_next >= {1'b0, limit});
endmodule

// File: rtl/run_fsm.sv
module run_fsm
    import run_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              limit_hit,
    input  logic [TIME_W-1:0] tod,
    output logic              running,
    output logic              start_now,
    output logic [TIME_W-1:0] stamp
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_req) state_d = ST_RUN;
            ST_RUN:  if (stop_req || limit_hit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign start_now = (state_q == ST_IDLE) && start_req;
    assign running   = (state_q == ST_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stamp <= '0;
        else if (start_now)
            stamp <= tod;
    end
endmodule

// File: rtl/run_ctrl_top.sv
module run_ctrl_top
    import run_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int LIMIT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic               ms_tick,
    input  logic               evt_accept,
    input  logic [TIME_W-1:0]  tod_in,
    output logic               run_active,
    output logic [TIME_W-1:0]  start_time,
    output logic               start_valid
);
    logic [1:0]         mode_q;
    logic [LIMIT_W-1:0] ms_limit, ev_limit;
    logic               ctrl_wr, start_req, stop_req, start_now;
    logic               ms_hit, ev_hit;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(IDX_CTRL));
    assign start_req = ctrl_wr &&  reg_wdata[0];
    assign stop_req  = ctrl_wr && !reg_wdata[0];

    run_regs #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .running(run_active), .stamp(start_time),
        .mode(mode_q), .ms_limit(ms_limit), .ev_limit(ev_limit),
        .rdata(reg_rdata)
    );

    run_limit #(.CNT_W(LIMIT_W)) u_ms (
        .clk(clk), .rst_n(rst_n), .clear(start_now), .running(run_active),
        .pulse(ms_tick), .enable(mode_q[0]), .limit(ms_limit), .hit(ms_hit)
    );

    run_limit #(.CNT_W(LIMIT_W)) u_ev (
        .clk(clk), .rst_n(rst_n), .clear(start_now), .running(run_active),
        .pulse(evt_accept), .enable(mode_q[1]), .limit(ev_limit), .hit(ev_hit)
    );

    run_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .limit_hit(ms_hit || ev_hit), .tod(tod_in), .running(run_active),
        .start_now(start_now), .stamp(start_time)
    );

    assign start_valid = (start_time[1:0] == FLAG_VALID);
endmodule

// File: rtl/run_ctrl_sva.sv
module run_ctrl_sva
    import run_ctrl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              ms_tick,
    input logic              evt_accept,
    input logic [TIME_W-1:0] tod_in,
    input logic              run_active,
    input logic [TIME_W-1:0] start_time,
    input logic [1:0]        mode_q
);
    logic wr_go, wr_halt;
    assign wr_go   = reg_wr && reg_addr == ADDR_W'(IDX_CTRL) &&  reg_wdata[0];
    assign wr_halt = reg_wr && reg_addr == ADDR_W'(IDX_CTRL) && !reg_wdata[0];

    p_stop_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_halt |=> !run_active);

    p_idle_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_active && !wr_go) |=> !run_active);

    p_manual_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && mode_q == 2'b00 && !wr_halt) |=> run_active);

    p_quiet_keeps_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && !wr_halt && !ms_tick && !evt_accept) |=> run_active);

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_active) |-> start_time == $past(tod_in));

    p_stamp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active || !wr_go) |=> $stable(start_time));
endmodule

bind run_ctrl_top run_ctrl_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ms_tick(ms_tick), .evt_accept(evt_accept),
    .tod_in(tod_in), .run_active(run_active), .start_time(start_time),
    .mode_q(mode_q)
);

// File: tb/run_ctrl_top_tb.sv
module run_ctrl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        ms_tick = 1'b0;
    logic        evt_accept = 1'b0;
    logic [63:0] tod_in = '0;
    logic        run_active;
    logic [63:0] start_time;
    logic        start_valid;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    run_ctrl_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ms_tick(ms_tick),
        .evt_accept(evt_accept), .tod_in(tod_in), .run_active(run_active),
        .start_time(start_time), .start_valid(start_valid)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] ms_lim;
        logic [15:0] ev_lim;
        logic [7:0]  n_tick;
        logic [7:0]  n_evt;
        logic        exp_run;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 16'd3,  16'd3,  8'd6, 8'd6, 1'b1},  // R4 manual only
        '{2'd1, 16'd5,  16'd0,  8'd4, 8'd0, 1'b1},  // R5 one short
        '{2'd1, 16'd5,  16'd0,  8'd5, 8'd0, 1'b0},  // R5 reached
        '{2'd1, 16'd0,  16'd0,  8'd1, 8'd0, 1'b0},  // R5 zero limit
        '{2'd1, 16'd5,  16'd0,  8'd0, 8'd9, 1'b1},  // R5 events ignored
        '{2'd2, 16'd0,  16'd4,  8'd0, 8'd3, 1'b1},  // R6 one short
        '{2'd2, 16'd0,  16'd4,  8'd0, 8'd4, 1'b0},  // R6 reached
        '{2'd2, 16'd0,  16'd4,  8'd9, 8'd0, 1'b1},  // R6 ticks ignored
        '{2'd3, 16'd3,  16'd10, 8'd3, 8'd0, 1'b0},  // R7 time first
        '{2'd3, 16'd10, 16'd2,  8'd0, 8'd2, 1'b0}   // R7 events first
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        ms_tick = 1'b1; @(negedge clk); ms_tick = 1'b0;
    endtask

    task automatic evt();
        evt_accept = 1'b1; @(negedge clk); evt_accept = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 run_active", run_active, 0);
        chk("R1 start_time", start_time, 0);
        chk("R1 start_valid", start_valid, 0);
        for (int i = 0; i < 16; i++) begin
            rd(i[3:0], d);
            chk("R1 reg reads zero", d, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register read-back and layout
        wr(4'd0, 16'hFFFF);
        rd(4'd0, d); chk("R2 mode bits", d, 16'h0003);
        wr(4'd6, 16'hA1B2); wr(4'd7, 16'hC3D4);
        wr(4'd8, 16'h1122); wr(4'd9, 16'h3344);
        rd(4'd6, d); chk("R2 ms limit low", d, 16'hA1B2);
        rd(4'd7, d); chk("R2 ms limit high", d, 16'hC3D4);
        rd(4'd8, d); chk("R2 ev limit low", d, 16'h1122);
        rd(4'd9, d); chk("R2 ev limit high", d, 16'h3344);
        wr(4'd12, 16'hBEEF);
        rd(4'd12, d); chk("R2 unmapped reads zero", d, 0);

        // R11 idle ticks and events must not count
        for (int i = 0; i < 6; i++) begin tick(); evt(); end
        chk("R3 idle stays idle", run_active, 0);

        // vector table: R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            wr(4'd0, {14'd0, VECS[v].mode});
            wr(4'd6, VECS[v].ms_lim); wr(4'd7, 16'd0);
            wr(4'd8, VECS[v].ev_lim); wr(4'd9, 16'd0);
            wr(4'd1, 16'd1);
            chk("R3 run started", run_active, 1);
            for (int t = 0; t < VECS[v].n_tick; t++) tick();
            for (int e = 0; e < VECS[v].n_evt; e++) evt();
            chk("R4/R5/R6/R7 vector outcome", run_active, VECS[v].exp_run);
            wr(4'd1, 16'd0);
        end

        // R9 R10 capture and layout
        wr(4'd0, 16'd0);
        tod_in = 64'h1234_5678_9ABC_DEF2;
        wr(4'd1, 16'd1);
        tod_in = 64'hFFFF_0000_FFFF_0001;
        @(negedge clk);
        chk("R9 start_time latched", start_time, 64'h1234_5678_9ABC_DEF2);
        chk("R10 flags 2 valid", start_valid, 1);
        rd(4'd1, d); chk("R3 status bit reads 1", d, 16'h0001);
        rd(4'd2, d); chk("R9 stamp word 0", d, 16'hDEF2);
        rd(4'd3, d); chk("R9 stamp word 1", d, 16'h9ABC);
        rd(4'd4, d); chk("R9 stamp word 2", d, 16'h5678);
        rd(4'd5, d); chk("R9 stamp word 3", d, 16'h1234);

        // R11 restart while running ignored
        wr(4'd1, 16'd1);
        chk("R11 still running", run_active, 1);
        chk("R11 stamp kept", start_time, 64'h1234_5678_9ABC_DEF2);

        // R8 stop, then invalid flags
        wr(4'd1, 16'd0);
        chk("R8 stopped", run_active, 0);
        rd(4'd1, d); chk("R3 status bit reads 0", d, 0);
        tod_in = 64'h0000_0001_0000_0003;
        wr(4'd1, 16'd1);
        chk("R10 flags 3 invalid", start_valid, 0);
        chk("R9 second capture", start_time, 64'h0000_0001_0000_0003);

        // R8 stop overrides in the same cycle as a non-final tick
        wr(4'd1, 16'd0);
        wr(4'd0, 16'd1); wr(4'd6, 16'd4); wr(4'd7, 16'd0);
        wr(4'd1, 16'd1);
        tick();
        ms_tick = 1'b1;
        wr(4'd1, 16'd0);
        ms_tick = 1'b0;
        chk("R8 stop with tick", run_active, 0);

        // R11 new run counts from zero after earlier ticks
        wr(4'd1, 16'd1);
        for (int i = 0; i < 3; i++) tick();
        chk("R11 counter restarted", run_active, 1);
        tick();
        chk("R5 fourth tick ends run", run_active, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule